// File: doc/BRIEF.md
# Four-Digit Sequence Detector

This block watches a stream of base-4 digits, one digit per rising clock edge on a narrow bus, and raises a flag whenever the last four digits form the sequence 3, 2, 0, 1. The flag is combinational from the current state and the digit now on the bus. It therefore rises within the cycle that brings the closing 1 and stays up until that cycle's inputs change at the next edge. After a hit the machine keeps scanning, so back-to-back and interleaved occurrences are all reported.

The search is held in a two-bit state register with four named states. IDLE (code 00) means no useful prefix has been seen. GOT_3 means the prefix 3 has been seen, GOT_32 means 3, 2 has been seen, and GOT_320 means 3, 2, 0 has been seen. The transitions are as follows:
- ADVANCE: on the expected digit, IDLE→GOT_3 on 3, GOT_3→GOT_32 on 2, and GOT_32→GOT_320 on 0.
- RESTART: a 3 in any state other than IDLE goes to GOT_3.
- MATCH: a 1 in GOT_320 goes to IDLE and raises the flag.
- DROP: any other digit goes to IDLE.

Reset is synchronous and active high. It clears the state register and also forces the flag low while it is high.

Top module: `digit_seq_detector`

## Requirements
- R1: A high reset sampled at a rising edge returns the machine to IDLE (code 00). A pattern cut by reset is never completed by the digits that follow reset.
- R2: While reset is high, the flag stays low, even when the state is GOT_320 and the digit on the bus is 1.
- R3: The flag goes high in the same cycle in which the digit 1 (binary 01 on the digit bus) follows, on consecutive edges, the digits 3 (11), 2 (10) and 0 (00), with reset low.
- R4: A repeated 3 keeps the prefix alive, so 3, 3, 2, 0, 1 is reported on its final digit.
- R5: A 3 that breaks a partial match starts a new one, so 3, 2, 3, 2, 0, 1 and 3, 2, 0, 3, 2, 0, 1 are each reported exactly once, on the final digit.
- R6: After a match the search resumes at once, so 3, 2, 0, 1, 3, 2, 0, 1 is reported twice.
- R7: Any digit that neither advances nor restarts the match drops to IDLE. Examples are 3, 2, 1, then 0, 1; and 3, 2, 0, 0, 1. No flag follows such a break.
- R8: The flag is high only on the cycle that completes the pattern and is low on every other cycle of an arbitrary digit stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DIGIT_W | Incoming digit, unsigned binary |
| det | output | 1 | Pattern-complete flag, combinational |

## Verification
The bench builds the block with its default DIGIT_W of 2, which is the only width at which every code on the bus is a legal digit. With that width, a random stream reaches every state/digit pair, including all RESTART and DROP arcs. A reference model keeps a history of the last three digits accepted since reset. Because the pattern has no self-overlap, the model must agree with the four-state machine on every cycle, including cycles where reset lands in the middle of a pattern.

// File: rtl/digit_seq_detector_pkg.sv
package digit_seq_detector_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_GOT3   = 2'b01,
        ST_GOT32  = 2'b10,
        ST_GOT320 = 2'b11
    } seq_state_e;

    // Pattern digits, first to last
    localparam int unsigned PAT_D0 = 3;
    localparam int unsigned PAT_D1 = 2;
    localparam int unsigned PAT_D2 = 0;
    localparam int unsigned PAT_D3 = 1;

endpackage

// File: rtl/digit_seq_state_reg.sv
module digit_seq_state_reg
    import digit_seq_detector_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_d,
    output seq_state_e state_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/digit_seq_next_state.sv
module digit_seq_next_state
    import digit_seq_detector_pkg::*;
#(
    parameter int unsigned DIGIT_W = 2
) (
    input  seq_state_e         state_q,
    input  logic [DIGIT_W-1:0] din,
    output seq_state_e         state_d
);

    localparam logic [DIGIT_W-1:0] K_D0 = DIGIT_W'(PAT_D0);
    localparam logic [DIGIT_W-1:0] K_D1 = DIGIT_W'(PAT_D1);
    localparam logic [DIGIT_W-1:0] K_D2 = DIGIT_W'(PAT_D2);

    logic restart;

    always_comb begin
        restart = (din == K_D0);
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:   state_d = restart ? ST_GOT3 : ST_IDLE;
            ST_GOT3:   state_d = (din == K_D1) ? ST_GOT32 :
                                 (restart ? ST_GOT3 : ST_IDLE);
            ST_GOT32:  state_d = (din == K_D2) ? ST_GOT320 :
                                 (restart ? ST_GOT3 : ST_IDLE);
            ST_GOT320: state_d = restart ? ST_GOT3 : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/digit_seq_output.sv
module digit_seq_output
    import digit_seq_detector_pkg::*;
#(
    parameter int unsigned DIGIT_W = 2
) (
    input  logic               rst,
    input  seq_state_e         state_q,
    input  logic [DIGIT_W-1:0] din,
    output logic               det
);

    localparam logic [DIGIT_W-1:0] K_D3 = DIGIT_W'(PAT_D3);

    always_comb begin
        det = 1'b0;
        unique case (state_q)
            ST_GOT320: det = !rst && (din == K_D3);
            ST_IDLE,
            ST_GOT3,
            ST_GOT32:  det = 1'b0;
            default:   det = 1'b0;
        endcase
    end

endmodule

// File: rtl/digit_seq_detector.sv
module digit_seq_detector
    import digit_seq_detector_pkg::*;
#(
    parameter int unsigned DIGIT_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] din,
    output logic               det
);

    seq_state_e state_q;
    seq_state_e state_d;

    digit_seq_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .state_q (state_q)
    );

    digit_seq_next_state #(.DIGIT_W(DIGIT_W)) u_next (
        .state_q (state_q),
        .din     (din),
        .state_d (state_d)
    );

    digit_seq_output #(.DIGIT_W(DIGIT_W)) u_out (
        .rst     (rst),
        .state_q (state_q),
        .din     (din),
        .det     (det)
    );

endmodule

// File: rtl/digit_seq_detector_chk.sv
module digit_seq_detector_chk
    import digit_seq_detector_pkg::*;
#(
    parameter int unsigned DIGIT_W = 2
) (
    input logic               clk,
    input logic               rst,
    input logic [DIGIT_W-1:0] din,
    input logic               det,
    input seq_state_e         state
);

    // R1: reset edge lands in IDLE
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));

    // R2: no flag during reset
    p_quiet_in_reset_r2: assert property (@(posedge clk)
        rst |-> !det);

    // R3: a flag implies the three preceding digits were 3, 2, 0
    p_det_history_r3: assert property (@(posedge clk) disable iff (rst)
        det |-> ($past(din, 1) == DIGIT_W'(PAT_D2)) &&
                ($past(din, 2) == DIGIT_W'(PAT_D1)) &&
                ($past(din, 3) == DIGIT_W'(PAT_D0)));

    // R6: after a match the machine is back in IDLE
    p_match_to_idle_r6: assert property (@(posedge clk) disable iff (rst)
        det |=> (state == ST_IDLE));

    // R5: a 3 always restarts the prefix
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (din == DIGIT_W'(PAT_D0)) |=> (state == ST_GOT3));

    // R7: an unexpected non-3 digit drops to IDLE
    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_GOT3) && (din != DIGIT_W'(PAT_D1)) &&
         (din != DIGIT_W'(PAT_D0))) |=> (state == ST_IDLE));

endmodule

bind digit_seq_detector digit_seq_detector_chk #(.DIGIT_W(DIGIT_W)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .det   (det),
    .state (state_q)
);

// File: tb/digit_seq_detector_tb.sv
`timescale 1ns/1ps
module digit_seq_detector_tb_top;

    localparam int unsigned DIGIT_W = 2;
    localparam real HALF = 2.5;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [DIGIT_W-1:0] din = '0;
    logic               det;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // reference model: history of accepted digits since reset
    int unsigned h1 = 0, h2 = 0, h3 = 0;
    int          n_acc = 0;
    bit          prev_rst = 1'b1;
    int unsigned prev_din = 0;

    bit    exp_q[$];
    string tag_q[$];

    always #(HALF) clk = ~clk;

    digit_seq_detector #(.DIGIT_W(DIGIT_W)) dut_i (
        .clk (clk),
        .rst (rst),
        .din (din),
        .det (det)
    );

    // driver: one digit per cycle, pushes the expected flag
    task automatic step(input bit r, input int unsigned d, input string tag);
        bit e;
        @(posedge clk);
        if (prev_rst) begin
            n_acc = 0;
        end else begin
            h3 = h2; h2 = h1; h1 = prev_din;
            n_acc = n_acc + 1;
        end
        #1;
        rst = r;
        din = DIGIT_W'(d);
        prev_rst = r;
        prev_din = d;
        e = !r && (n_acc >= 3) && (h3 == 3) && (h2 == 2) && (h1 == 0) && (d == 1);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic seq(input int unsigned a[], input string tag);
        foreach (a[i]) step(1'b0, a[i], tag);
    endtask

    // monitor: compare mid-cycle, after the digit has settled
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (det !== e) begin
                errors++;
                $display("FAIL %s: det=%b expected=%b at %0t", t, det, e, $time);
            end
        end
    end

    initial begin
        #(200000 * 2 * HALF);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset held; flag low even with 1 on the bus (R2)
        step(1'b1, 1, "R2");
        step(1'b1, 3, "R2");
        // basic match R3
        seq('{3, 2, 0, 1}, "R3");
        // repeated 3 R4
        seq('{3, 3, 2, 0, 1}, "R4");
        // restart cases R5
        seq('{3, 2, 3, 2, 0, 1}, "R5");
        seq('{3, 2, 0, 3, 2, 0, 1}, "R5");
        // back to back R6
        seq('{3, 2, 0, 1, 3, 2, 0, 1}, "R6");
        // drop cases R7
        seq('{3, 2, 1, 0, 1}, "R7");
        seq('{3, 2, 0, 0, 1}, "R7");
        seq('{2, 0, 1, 1, 0, 1}, "R7");
        // reset mid-pattern, then the tail R1
        seq('{3, 2, 0}, "R1");
        step(1'b1, 2, "R1");
        seq('{0, 1, 1}, "R1");
        // reset on the closing cycle R2
        seq('{3, 2, 0}, "R2");
        step(1'b1, 1, "R2");
        step(1'b0, 1, "R2");
        // random stream with planted patterns R8
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 19) == 0) begin
                seq('{3, 2, 0, 1}, "R8");
            end else if ($urandom_range(0, 199) == 0) begin
                step(1'b1, $urandom_range(0, 3), "R8");
            end else begin
                step(1'b0, $urandom_range(0, 3), "R8");
            end
        end
        step(1'b0, 0, "R8");
        @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule